// File: doc/BRIEF.md
# Accumulator Add/Subtract Unit With Sticky Overflow

This block is the single-cycle arithmetic path of a 16-bit two's-complement machine with two accumulators, A and B. The sign lives in the most significant position. In a `[15:0]` vector that is position 15, and the bit just below it is position 14.

The core presents an already fetched memory word with a three-bit operation code and a valid strobe. The block updates the addressed accumulator and a sticky overflow latch. One cycle later it answers with a done pulse. For the overflow test operation it also returns how many following instructions the sequencer must skip.

Overflow is detected on the effective addition. It is flagged when both addends carry the same sign and the sum carries the other sign. Once set, the latch holds until reset or until the test operation consumes it. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `acc_arith_unit`

## Requirements
- R1: After reset, acc_a, acc_b, ovf_flag, op_done and skip_cnt are all zero.
- R2: op_code 0 (add to A) replaces A with A plus mem_word, modulo 2^16, and leaves B unchanged.
- R3: op_code 1 (add to B) replaces B with B plus mem_word, modulo 2^16, and leaves A unchanged.
- R4: op_code 2 (subtract from A) replaces A with A plus the two's complement of mem_word, modulo 2^16, and leaves B unchanged.
- R5: An add, subtract or round whose signed result lies outside -32768..32767 sets ovf_flag.
- R6: ovf_flag is never cleared by an arithmetic operation, whether or not that operation overflows.
- R7: op_code 3 (round) adds one to A when B[14], the bit just below B's sign, is one, and leaves A unchanged otherwise. Rounding 0x7FFF up gives 0x8000 and sets ovf_flag.
- R8: op_code 4 sets ovf_flag and leaves both accumulators unchanged.
- R9: op_code 5 (skip on no overflow) works as follows. With the latch set, it clears the latch and reports skip_cnt 0. With the latch clear, it reports skip_cnt 1.
- R10: op_done is high in exactly the cycle after each cycle with op_valid high. skip_cnt is zero whenever op_done is low. Back-to-back operations on consecutive cycles are all accepted.
- R11: op_codes 6 and 7 produce a done pulse and change neither accumulator nor ovf_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe, one operation per high cycle |
| op_code | input | 3 | Operation select (see R2 to R11) |
| mem_word | input | 16 | Fetched memory operand |
| op_done | output | 1 | One-cycle completion pulse |
| acc_a | output | 16 | A accumulator |
| acc_b | output | 16 | B accumulator |
| ovf_flag | output | 1 | Sticky overflow latch |
| skip_cnt | output | 2 | Number of following instructions to skip, valid with op_done |

## Verification
The embedded properties check several behaviours on every cycle:
- the done pulse following each strobe, and its absence otherwise;
- the latch holding unless the test operation clears it;
- the set operation leaving the accumulators untouched;
- add-to-B leaving A untouched;
- the test operation reporting a skip when the latch is clear.

Only the bench's scenarios can show that the sums and differences have the right values. The same holds for the edges of the overflow range, including subtracting the most negative word, and for rounding keyed on B's second bit. A behavioural integer model compares every output on every cycle, through directed corner cases and a long random back-to-back stream.

// File: rtl/acc_arith_pkg.sv
package acc_arith_pkg;
  localparam int OPW = 3;
  localparam logic [OPW-1:0] OP_ADD_A   = 3'd0;
  localparam logic [OPW-1:0] OP_ADD_B   = 3'd1;
  localparam logic [OPW-1:0] OP_SUB_A   = 3'd2;
  localparam logic [OPW-1:0] OP_ROUND_A = 3'd3;
  localparam logic [OPW-1:0] OP_SET_OV  = 3'd4;
  localparam logic [OPW-1:0] OP_TEST_OV = 3'd5;
endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/acc_adder.sv
module acc_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] aug_i,
  input  logic [W-1:0] addend_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  always_comb begin
    sum_o = aug_i + addend_i + {{(W-1){1'b0}}, cin_i};
    ovf_o = (aug_i[W-1] == addend_i[W-1]) && (sum_o[W-1] != aug_i[W-1]);
  end
endmodule

// File: rtl/acc_ovf_latch.sv
module acc_ovf_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic q_q;

  always_comb begin
    q_d = q_q;
    if (set_i)      q_d = 1'b1;
    else if (clr_i) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // R6
  hold_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_q && !clr_i) |=> q_q);

  // R5
  set_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_q);
endmodule

// File: rtl/acc_arith_unit.sv
module acc_arith_unit
  import acc_arith_pkg::*;
#(
  parameter int W     = 16,
  parameter int SKIPW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [OPW-1:0]   op_code,
  input  logic [W-1:0]     mem_word,
  output logic             op_done,
  output logic [W-1:0]     acc_a,
  output logic [W-1:0]     acc_b,
  output logic             ovf_flag,
  output logic [SKIPW-1:0] skip_cnt
);
  localparam int RND_BIT = W - 2;

  logic             rst_sync_n;
  logic [W-1:0]     a_q, a_d, b_q, b_d;
  logic             done_q;
  logic [SKIPW-1:0] skip_q, skip_d;
  logic [W-1:0]     aug, addend, sum;
  logic             cin, add_ovf;
  logic             is_arith, ov_set, ov_clr, ov_q;

  acc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // operand steering for the shared adder
  always_comb begin
    aug    = (op_code == OP_ADD_B) ? b_q : a_q;
    addend = '0;
    cin    = 1'b0;
    case (op_code)
      OP_ADD_A, OP_ADD_B: addend = mem_word;
      OP_SUB_A: begin addend = ~mem_word; cin = 1'b1; end
      OP_ROUND_A: cin = b_q[RND_BIT];
      default: ;
    endcase
  end

  acc_adder #(.W(W)) u_add (
    .aug_i(aug), .addend_i(addend), .cin_i(cin), .sum_o(sum), .ovf_o(add_ovf)
  );

  // next state
  always_comb begin
    is_arith = (op_code == OP_ADD_A) || (op_code == OP_ADD_B) ||
               (op_code == OP_SUB_A) || (op_code == OP_ROUND_A);
    a_d    = a_q;
    b_d    = b_q;
    skip_d = '0;
    if (op_valid) begin
      if (op_code == OP_ADD_A || op_code == OP_SUB_A || op_code == OP_ROUND_A) a_d = sum;
      if (op_code == OP_ADD_B) b_d = sum;
      if (op_code == OP_TEST_OV && !ov_q) skip_d = SKIPW'(1);
    end
    ov_set = op_valid && ((is_arith && add_ovf) || (op_code == OP_SET_OV));
    ov_clr = op_valid && (op_code == OP_TEST_OV);
  end

  acc_ovf_latch u_ovf (
    .clk(clk), .rst_n(rst_sync_n), .set_i(ov_set), .clr_i(ov_clr), .q_o(ov_q)
  );

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      a_q    <= '0;
      b_q    <= '0;
      done_q <= 1'b0;
      skip_q <= '0;
    end else begin
      a_q    <= a_d;
      b_q    <= b_d;
      done_q <= op_valid;
      skip_q <= skip_d;
    end
  end

  assign acc_a    = a_q;
  assign acc_b    = b_q;
  assign op_done  = done_q;
  assign ovf_flag = ov_q;
  assign skip_cnt = skip_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid |=> op_done);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid |=> (!op_done && skip_cnt == '0));

  // R9
  skip_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == OP_TEST_OV && !ovf_flag) |=> (skip_cnt == SKIPW'(1) && !ovf_flag));

  // R9
  consume_ovf_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == OP_TEST_OV && ovf_flag) |=> (skip_cnt == '0 && !ovf_flag));

  // R8
  set_ov_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == OP_SET_OV) |=> (ovf_flag && $stable(acc_a) && $stable(acc_b)));

  // R3
  add_b_keeps_a_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == OP_ADD_B) |=> $stable(acc_a));
endmodule

// File: tb/acc_arith_unit_tb.sv
module acc_arith_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = 3'd0;
  logic [15:0] in_m = 16'd0;
  logic        op_done, ovf_flag;
  logic [15:0] acc_a, acc_b;
  logic [1:0]  skip_cnt;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit cmp_en = 0;
  bit finished = 0;

  logic [15:0] m_a, m_b;
  logic        m_ov, m_done;
  logic [1:0]  m_skip;
  string       m_tag = "R10";

  always #10 clk = ~clk;

  acc_arith_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(in_valid), .op_code(in_op),
    .mem_word(in_m), .op_done(op_done), .acc_a(acc_a), .acc_b(acc_b),
    .ovf_flag(ovf_flag), .skip_cnt(skip_cnt)
  );

  function automatic int sx(logic [15:0] v);
    return v[15] ? int'(v) - 65536 : int'(v);
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    int s;
    if (!rst_n) begin
      m_a <= 0; m_b <= 0; m_ov <= 0; m_done <= 0; m_skip <= 0; m_tag <= "R1";
    end else begin
      m_done <= in_valid;
      m_skip <= 0;
      if (!in_valid) m_tag <= "R10";
      else begin
        case (in_op)
          3'd0: begin s = sx(m_a) + sx(in_m); m_a <= s[15:0];
                  if (s > 32767 || s < -32768) m_ov <= 1; m_tag <= "R2"; end
          3'd1: begin s = sx(m_b) + sx(in_m); m_b <= s[15:0];
                  if (s > 32767 || s < -32768) m_ov <= 1; m_tag <= "R3"; end
          3'd2: begin s = sx(m_a) - sx(in_m); m_a <= s[15:0];
                  if (s > 32767 || s < -32768) m_ov <= 1; m_tag <= "R4"; end
          3'd3: begin s = sx(m_a) + (m_b[14] ? 1 : 0); m_a <= s[15:0];
                  if (s > 32767) m_ov <= 1; m_tag <= "R7"; end
          3'd4: begin m_ov <= 1; m_tag <= "R8"; end
          3'd5: begin if (m_ov) m_ov <= 0; else m_skip <= 1; m_tag <= "R9"; end
          default: m_tag <= "R11";
        endcase
      end
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(m_tag, "acc_a", acc_a, m_a);
      chk(m_tag, "acc_b", acc_b, m_b);
      chk(m_tag, "ovf_flag", ovf_flag, m_ov);
      chk("R10", "op_done", op_done, m_done);
      chk(m_tag, "skip_cnt", skip_cnt, m_skip);
    end
  end

  task automatic do_op(logic [2:0] op, logic [15:0] m);
    @(negedge clk);
    in_valid = 1; in_op = op; in_m = m;
    @(negedge clk);
    in_valid = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "acc_a", acc_a, 0);
    chk("R1", "acc_b", acc_b, 0);
    chk("R1", "ovf_flag", ovf_flag, 0);
    chk("R1", "op_done", op_done, 0);
    chk("R1", "skip_cnt", skip_cnt, 0);
    cmp_en = 1;

    do_op(3'd0, 16'd5);      chk("R2", "add A", acc_a, 16'd5);
    do_op(3'd1, 16'h7FFF);   chk("R3", "add B", acc_b, 16'h7FFF);
    chk("R3", "A kept", acc_a, 16'd5);
    do_op(3'd1, 16'd1);      chk("R5", "B wrap", acc_b, 16'h8000);
    chk("R5", "ovf set", ovf_flag, 1);
    do_op(3'd5, 16'd0);      chk("R9", "skip with latch", skip_cnt, 0);
    chk("R9", "latch cleared", ovf_flag, 0);
    do_op(3'd5, 16'd0);      chk("R9", "skip without latch", skip_cnt, 1);
    do_op(3'd0, 16'd3);      chk("R2", "add A again", acc_a, 16'd8);
    do_op(3'd4, 16'h1234);   chk("R8", "set ov", ovf_flag, 1);
    chk("R8", "A unchanged", acc_a, 16'd8);
    do_op(3'd0, 16'd1);      chk("R6", "latch sticky", ovf_flag, 1);
    do_op(3'd5, 16'd0);
    do_op(3'd2, 16'h8000);   chk("R4", "sub min", acc_a, 16'h8009);
    chk("R5", "sub min ovf", ovf_flag, 1);
    do_op(3'd5, 16'd0);
    do_op(3'd3, 16'd0);      chk("R7", "no round, B14=0", acc_a, 16'h8009);
    do_op(3'd1, 16'h4000);   chk("R3", "B now C000", acc_b, 16'hC000);
    do_op(3'd3, 16'd0);      chk("R7", "round up", acc_a, 16'h800A);
    do_op(3'd2, 16'h800A);   chk("R4", "sub to zero", acc_a, 16'd0);
    chk("R6", "no ovf", ovf_flag, 0);
    do_op(3'd0, 16'h7FFF);
    do_op(3'd3, 16'd0);      chk("R7", "round max", acc_a, 16'h8000);
    chk("R7", "round ovf", ovf_flag, 1);
    do_op(3'd6, 16'hFFFF);   chk("R11", "op6 A", acc_a, 16'h8000);
    chk("R11", "op6 ovf", ovf_flag, 1);
    do_op(3'd7, 16'h0001);   chk("R11", "op7 B", acc_b, 16'hC000);
    chk("R10", "done op7", op_done, 1);

    // back-to-back random stream
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      in_valid = ($urandom_range(0, 4) != 0);
      in_op = 3'($urandom_range(0, 7));
      in_m = 16'($urandom);
    end
    @(negedge clk);
    in_valid = 0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule